// File: doc/BRIEF.md
# Exception Entry Stacking Sequencer

This block carries a processor through exception entry. Once an exception request is taken, it saves a frame of eight core registers below the current stack pointer. The writes go through a word-wide memory write port, one word per accepted beat. When the last word is accepted it commits the lowered stack pointer. It then reads the handler start address from a vector table and presents that address to the core, with bit 0 cleared.

The vector table has one 32-bit entry per exception number. Entry zero holds the initial main stack pointer rather than a handler. The table base lives in an internal register that resets to zero. Software can rewrite it, and the register keeps the table on a 128-byte boundary.

A request can arrive while the block is busy. If its priority value is numerically lower, it replaces the exception being entered, and the vector fetch then uses the new number. The frame already being written stays as it is: nothing is pushed a second time.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset `busy`, `wr_req`, `rd_req`, `sp_upd` and `handler_valid` are low, and the vector base is 0x0000_0000.
- R2: A `req_valid` while idle is accepted, and `busy` is high in the next cycle. The block latches `sp_in` and `save_regs` at acceptance and ignores later changes to them.
- R3: Stacking issues exactly eight writes. Word k of `save_regs` (bits 32k+31:32k, with k = 0..7 standing for r0, r1, r2, r3, r12, LR, PC, xPSR) is written to original SP − 32 + 4k. Writes are issued from k = 7 (at SP − 4) down to k = 0. Each write holds its address and data until `wr_ready`.
- R4: In the cycle after the eighth write is accepted, and never before, `sp_upd` pulses for one cycle with `sp_out` = original SP − 32.
- R5: `rd_req` is raised from the cycle of `sp_upd` until the vector word is taken. `rd_addr` = vector base + 4 × current exception number.
- R6: In the cycle after `rd_ready` is taken, `handler_valid` pulses for one cycle. `handler_addr` is `rd_data` with bit 0 cleared, `handler_num` is the exception taken, and `busy` is low in that cycle.
- R7: While busy, a `req_valid` whose `req_prio` is numerically lower than that of the current exception replaces the exception number. The total number of writes stays at eight.
- R8: While busy, a `req_valid` whose priority value is equal to or higher than the current one has no effect on the vector address or on the handler taken.
- R9: If a replacing request arrives in the same cycle as `rd_ready`, the returned word is discarded. No handler is signalled, and the read is reissued at the new vector address.
- R10: A write to the vector base stores `vbase_wdata` with bits 6:0 forced to zero.
- R11: `wr_req` and `rd_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Exception request |
| req_num | input | NUM_W | Exception number of the request |
| req_prio | input | PRIO_W | Priority value (lower is more urgent) |
| save_regs | input | 256 | Eight register values to save, word k as in R3 |
| sp_in | input | 32 | Stack pointer at acceptance |
| vbase_we | input | 1 | Vector base write strobe |
| vbase_wdata | input | 32 | Vector base write data |
| wr_req | output | 1 | Stack write request |
| wr_addr | output | 32 | Stack write byte address |
| wr_data | output | 32 | Stack write data |
| wr_ready | input | 1 | Write accepted this cycle |
| rd_req | output | 1 | Vector read request |
| rd_addr | output | 32 | Vector read byte address |
| rd_ready | input | 1 | Read data valid and accepted this cycle |
| rd_data | input | 32 | Vector word |
| busy | output | 1 | Entry in progress |
| sp_out | output | 32 | Committed new stack pointer |
| sp_upd | output | 1 | One-cycle pulse when `sp_out` is committed |
| handler_valid | output | 1 | One-cycle pulse when the handler address is ready |
| handler_addr | output | 32 | Handler start address |
| handler_num | output | NUM_W | Exception number being entered |

## Verification
Two events can fall in the same cycle: a replacing request and either the completion of the vector read or the acceptance of a stack write. The bench covers the first case by raising a more urgent request in exactly the cycle it grants `rd_ready`. It then expects no handler pulse in the next cycle, and a read reissued at the new table address. The second case comes up in the sweep, which moves the injection cycle across the stacking phase under changing write stall patterns. For every entry the bench checks that the write count stays at eight and that the handler number is the last winning request.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int WORD_W      = 32;
    localparam int WORD_BYTES  = WORD_W / 8;
    localparam int FRAME_WORDS = 8;
    localparam int FRAME_IDX_W = $clog2(FRAME_WORDS);
    localparam int FRAME_BITS  = FRAME_WORDS * WORD_W;
    localparam logic [WORD_W-1:0] FRAME_BYTES = WORD_W'(FRAME_WORDS * WORD_BYTES);

    typedef enum logic [1:0] {
        ENT_IDLE,
        ENT_STACK,
        ENT_VECTOR
    } ent_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } wr_beat_t;

    // Byte address of the issue-th write (issue 0 lands just below top)
    function automatic logic [WORD_W-1:0] slot_addr(
        input logic [WORD_W-1:0]      top,
        input logic [FRAME_IDX_W-1:0] issue
    );
        return top - ((WORD_W'(issue) + WORD_W'(1)) * WORD_W'(WORD_BYTES));
    endfunction

    // Byte address of the vector entry for exception number num
    function automatic logic [WORD_W-1:0] vec_addr(
        input logic [WORD_W-1:0] base,
        input logic [WORD_W-1:0] num
    );
        return base + num * WORD_W'(WORD_BYTES);
    endfunction

endpackage

// File: rtl/exc_vbase_reg.sv
module exc_vbase_reg
    import exc_entry_pkg::*;
#(
    parameter int ALIGN_LSB = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] base
);

    localparam logic [WORD_W-1:0] KEEP_MASK =
        ~((WORD_W'(1) << ALIGN_LSB) - WORD_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            base <= '0;
        end else if (we) begin
            base <= wdata & KEEP_MASK;
        end
    end

endmodule

// File: rtl/exc_stacker.sv
module exc_stacker
    import exc_entry_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [WORD_W-1:0]     sp_in,
    input  logic [FRAME_BITS-1:0] frame_in,
    input  logic                  wr_ready,
    output logic                  wr_req,
    output wr_beat_t              beat,
    output logic                  done,
    output logic [WORD_W-1:0]     sp_new
);

    localparam logic [FRAME_IDX_W-1:0] LAST_IDX = FRAME_IDX_W'(FRAME_WORDS - 1);

    logic [WORD_W-1:0]      frame_q [FRAME_WORDS];
    logic [FRAME_IDX_W-1:0] idx_q;
    logic [FRAME_IDX_W-1:0] slot;
    logic [WORD_W-1:0]      sp_q;
    logic                   active_q;

    for (genvar k = 0; k < FRAME_WORDS; k++) begin : g_frame
        always_ff @(posedge clk) begin
            if (rst) begin
                frame_q[k] <= '0;
            end else if (start) begin
                frame_q[k] <= frame_in[k*WORD_W +: WORD_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            sp_q     <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            idx_q    <= '0;
            sp_q     <= sp_in;
        end else if (active_q && wr_ready) begin
            if (idx_q == LAST_IDX) begin
                active_q <= 1'b0;
            end
            idx_q <= idx_q + 1'b1;
        end
    end

    // Highest frame word goes out first, at the highest address
    always_comb begin
        slot       = LAST_IDX - idx_q;
        wr_req     = active_q;
        beat.addr  = slot_addr(sp_q, idx_q);
        beat.data  = frame_q[slot];
        done       = active_q && wr_ready && (idx_q == LAST_IDX);
        sp_new     = sp_q - FRAME_BYTES;
    end

endmodule

// File: rtl/exc_prio_track.sv
module exc_prio_track #(
    parameter int NUM_W  = 6,
    parameter int PRIO_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              busy,
    input  logic              req_valid,
    input  logic [NUM_W-1:0]  req_num,
    input  logic [PRIO_W-1:0] req_prio,
    output logic [NUM_W-1:0]  cur_num,
    output logic              late
);

    logic [PRIO_W-1:0] cur_prio_q;

    assign late = busy && req_valid && (req_prio < cur_prio_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_num    <= '0;
            cur_prio_q <= '0;
        end else if (load || late) begin
            cur_num    <= req_num;
            cur_prio_q <= req_prio;
        end
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int NUM_W     = 6,
    parameter int PRIO_W    = 3,
    parameter int ALIGN_LSB = 7
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [NUM_W-1:0]      req_num,
    input  logic [PRIO_W-1:0]     req_prio,
    input  logic [FRAME_BITS-1:0] save_regs,
    input  logic [WORD_W-1:0]     sp_in,
    input  logic                  vbase_we,
    input  logic [WORD_W-1:0]     vbase_wdata,
    output logic                  wr_req,
    output logic [WORD_W-1:0]     wr_addr,
    output logic [WORD_W-1:0]     wr_data,
    input  logic                  wr_ready,
    output logic                  rd_req,
    output logic [WORD_W-1:0]     rd_addr,
    input  logic                  rd_ready,
    input  logic [WORD_W-1:0]     rd_data,
    output logic                  busy,
    output logic [WORD_W-1:0]     sp_out,
    output logic                  sp_upd,
    output logic                  handler_valid,
    output logic [WORD_W-1:0]     handler_addr,
    output logic [NUM_W-1:0]      handler_num
);

    ent_state_e        state_q;
    logic              accept;
    logic              stack_done;
    logic              late;
    logic [NUM_W-1:0]  cur_num;
    logic [WORD_W-1:0] vbase;
    logic [WORD_W-1:0] sp_new;
    wr_beat_t          beat;

    assign busy   = (state_q != ENT_IDLE);
    assign accept = (state_q == ENT_IDLE) && req_valid;

    exc_vbase_reg #(
        .ALIGN_LSB(ALIGN_LSB)
    ) u_vbase (
        .clk   (clk),
        .rst   (rst),
        .we    (vbase_we),
        .wdata (vbase_wdata),
        .base  (vbase)
    );

    exc_stacker u_stack (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .sp_in    (sp_in),
        .frame_in (save_regs),
        .wr_ready (wr_ready),
        .wr_req   (wr_req),
        .beat     (beat),
        .done     (stack_done),
        .sp_new   (sp_new)
    );

    exc_prio_track #(
        .NUM_W  (NUM_W),
        .PRIO_W (PRIO_W)
    ) u_prio (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .busy      (busy),
        .req_valid (req_valid),
        .req_num   (req_num),
        .req_prio  (req_prio),
        .cur_num   (cur_num),
        .late      (late)
    );

    assign wr_addr = beat.addr;
    assign wr_data = beat.data;
    assign rd_req  = (state_q == ENT_VECTOR);
    assign rd_addr = vec_addr(vbase, WORD_W'(cur_num));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ENT_IDLE;
            sp_out        <= '0;
            sp_upd        <= 1'b0;
            handler_valid <= 1'b0;
            handler_addr  <= '0;
            handler_num   <= '0;
        end else begin
            sp_upd        <= 1'b0;
            handler_valid <= 1'b0;
            case (state_q)
                ENT_IDLE: begin
                    if (accept) begin
                        state_q <= ENT_STACK;
                    end
                end
                ENT_STACK: begin
                    if (stack_done) begin
                        state_q <= ENT_VECTOR;
                        sp_out  <= sp_new;
                        sp_upd  <= 1'b1;
                    end
                end
                ENT_VECTOR: begin
                    // A replacing request voids the word returned this cycle
                    if (rd_ready && !late) begin
                        handler_addr  <= rd_data & ~WORD_W'(1);
                        handler_valid <= 1'b1;
                        handler_num   <= cur_num;
                        state_q       <= ENT_IDLE;
                    end
                end
                default: state_q <= ENT_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [31:0] sp_in,
    input logic        wr_req,
    input logic [31:0] wr_addr,
    input logic [31:0] wr_data,
    input logic        wr_ready,
    input logic        rd_req,
    input logic [31:0] rd_addr,
    input logic        busy,
    input logic [31:0] sp_out,
    input logic        sp_upd,
    input logic        handler_valid,
    input logic [31:0] handler_addr
);

    logic [31:0] taken_sp;

    always_ff @(posedge clk) begin
        if (rst) begin
            taken_sp <= '0;
        end else if (!busy && req_valid) begin
            taken_sp <= sp_in;
        end
    end

    // R11
    port_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_req && rd_req));

    // R3
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        wr_req && !wr_ready |=> wr_req && $stable(wr_addr) && $stable(wr_data));

    // R4
    sp_step_chk: assert property (@(posedge clk) disable iff (rst)
        sp_upd |-> sp_out == taken_sp - 32'd32);

    // R4
    sp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sp_upd |=> !sp_upd);

    // R6
    hnd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        handler_valid |-> !handler_addr[0] && !busy);

    // R5
    vec_align_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> rd_addr[1:0] == 2'b00 && busy);

    // R6
    hnd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        handler_valid |=> !handler_valid);

endmodule

bind exc_entry_seq exc_entry_seq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .sp_in         (sp_in),
    .wr_req        (wr_req),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .wr_ready      (wr_ready),
    .rd_req        (rd_req),
    .rd_addr       (rd_addr),
    .busy          (busy),
    .sp_out        (sp_out),
    .sp_upd        (sp_upd),
    .handler_valid (handler_valid),
    .handler_addr  (handler_addr)
);

// File: tb/sim_exc_entry_seq.sv
module sim_exc_entry_seq;

    localparam int NUM_W  = 6;
    localparam int PRIO_W = 3;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic [NUM_W-1:0]  req_num;
    logic [PRIO_W-1:0] req_prio;
    logic [255:0]      save_regs;
    logic [31:0]       sp_in;
    logic              vbase_we;
    logic [31:0]       vbase_wdata;
    logic              wr_req;
    logic [31:0]       wr_addr;
    logic [31:0]       wr_data;
    logic              wr_ready;
    logic              rd_req;
    logic [31:0]       rd_addr;
    logic              rd_ready;
    logic [31:0]       rd_data;
    logic              busy;
    logic [31:0]       sp_out;
    logic              sp_upd;
    logic              handler_valid;
    logic [31:0]       handler_addr;
    logic [NUM_W-1:0]  handler_num;

    int          n_cmp = 0;
    int          n_bad = 0;
    bit          all_done = 1'b0;
    logic [31:0] base_m = 32'h0;

    always #10 clk = ~clk;

    exc_entry_seq #(.NUM_W(NUM_W), .PRIO_W(PRIO_W)) u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    function automatic logic [31:0] vec_word(input logic [31:0] a);
        return {a[15:0], a[15:0]} ^ 32'h0000_0101;
    endfunction

    task automatic run_entry(input int num, input int prio, input logic [31:0] sp,
                             input int seed, input int late_at, input int lnum,
                             input int lprio, input bit late_on_read);
        logic [255:0] regs;
        int           w = 0;
        int           exp_num = num;
        int           cur_p = prio;
        bit           hpend = 1'b0;
        bit           sp_seen = 1'b0;
        bit           fin = 1'b0;
        bit           injected = 1'b0;
        logic [31:0]  h_addr_exp = '0;
        int           h_num_exp = 0;
        for (int k = 0; k < 8; k++) begin
            regs[32*k +: 32] = 32'hC0DE_0000 ^ (32'(num) << 12) ^ (32'(k) << 4) ^ {16'h0, sp[15:0]};
        end
        @(negedge clk);
        req_valid = 1'b1;
        req_num   = NUM_W'(num);
        req_prio  = PRIO_W'(prio);
        sp_in     = sp;
        save_regs = regs;
        @(negedge clk);
        req_valid = 1'b0;
        // R2: busy follows acceptance; later input changes must not matter
        chk("R2 busy after accept", 32'(busy), 32'd1);
        sp_in     = ~sp;
        save_regs = ~regs;
        for (int c = 0; c < 300 && !fin; c++) begin
            logic [31:0] exp_rd;
            bit          inj;
            bit          late_eff;
            bit          rdy_w;
            bit          rdy_r;
            // R6
            chk("R6 handler_valid timing", 32'(handler_valid), 32'(hpend));
            if (hpend) begin
                chk("R6 handler_addr", handler_addr, h_addr_exp);
                chk("R6 R7 R8 handler_num", 32'(handler_num), 32'(h_num_exp));
                chk("R6 busy low with handler", 32'(busy), 32'd0);
                chk("R7 total writes", 32'(w), 32'd8);
                wr_ready  = 1'b0;
                rd_ready  = 1'b0;
                req_valid = 1'b0;
                fin = 1'b1;
            end else begin
                // R4
                chk("R4 sp_upd timing", 32'(sp_upd), 32'(w == 8 && !sp_seen));
                if (sp_upd) begin
                    chk("R4 sp_out", sp_out, sp - 32'd32);
                    sp_seen = 1'b1;
                end
                // R3 and R11: writes only while the frame is incomplete, read only after
                chk("R3 wr_req", 32'(wr_req), 32'(w < 8));
                chk("R11 R5 rd_req", 32'(rd_req), 32'(w == 8));
                if (wr_req) begin
                    chk("R3 wr_addr", wr_addr, sp - 32'd4 * 32'(w + 1));
                    chk("R3 wr_data", wr_data, regs[32*(7-w) +: 32]);
                end
                exp_rd = base_m + 32'd4 * 32'(exp_num);
                if (rd_req) begin
                    chk("R5 R1 R10 rd_addr", rd_addr, exp_rd);
                end
                inj   = late_on_read ? (rd_req && !injected) : (c == late_at);
                rdy_w = (seed == 0) || (((c * 5 + seed) % 3) != 0);
                rdy_r = late_on_read ? 1'b1 : (((c + seed) % 3) != 0);
                if (inj) injected = 1'b1;
                wr_ready = wr_req && rdy_w;
                rd_ready = rd_req && rdy_r;
                rd_data  = vec_word(exp_rd);
                req_valid = inj;
                req_num   = NUM_W'(lnum);
                req_prio  = PRIO_W'(lprio);
                // R7 R8 R9: only a strictly lower value replaces; it voids a same-cycle read
                late_eff = inj && (lprio < cur_p);
                hpend = rd_req && rdy_r && !late_eff;
                h_addr_exp = vec_word(exp_rd) & ~32'd1;
                h_num_exp  = exp_num;
                if (wr_req && rdy_w) w++;
                if (late_eff) begin
                    exp_num = lnum;
                    cur_p   = lprio;
                end
                @(negedge clk);
            end
        end
        if (!fin) chk("R6 entry did not finish", 32'd0, 32'd1);
    endtask

    task automatic set_base(input logic [31:0] v);
        @(negedge clk);
        vbase_we    = 1'b1;
        vbase_wdata = v;
        @(negedge clk);
        vbase_we = 1'b0;
        base_m   = v & ~32'h7F; // R10
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!all_done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_num = '0; req_prio = '0; save_regs = '0;
        sp_in = '0; vbase_we = 1'b0; vbase_wdata = '0; wr_ready = 1'b0;
        rd_ready = 1'b0; rd_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 wr_req", 32'(wr_req), 32'd0);
        chk("R1 rd_req", 32'(rd_req), 32'd0);
        chk("R1 sp_upd", 32'(sp_upd), 32'd0);
        chk("R1 handler_valid", 32'(handler_valid), 32'd0);

        // R1: first sweep runs with the reset base of zero
        for (int n = 0; n < 64; n++) begin
            run_entry(n, n % 8, 32'h2000_8000 - 32'(n * 96), n % 4, n % 14,
                      (n * 7 + 3) % 64, (n * 3) % 8, 1'b0);
        end

        // R10: low bits of the written base are dropped
        set_base(32'h1234_5EFF);
        for (int n = 0; n < 32; n++) begin
            run_entry(n, 4 + (n % 4), 32'h0001_0000 + 32'(n * 8), (n + 1) % 4, 99,
                      (n * 5 + 1) % 64, n % 8, 1'b1); // R9 collisions
        end

        set_base(32'hFFFF_FFFF);
        for (int n = 56; n < 64; n++) begin
            run_entry(n, 7, 32'h0000_0040 + 32'(n * 4), n % 4, (n * 3) % 12,
                      63 - n, n % 8, 1'b0);
        end

        all_done = 1'b1;
        report();
        $finish;
    end

endmodule